// File: doc/BRIEF.md
# Word-Buffered Serial Transmitter

This block takes 32-bit words from a processor-side write strobe, holds them in a small first-in first-out store, and sends each one out on a single asynchronous serial line. Every stored word becomes four byte frames, starting with its low byte. Each frame has one start bit, eight data bits, one odd parity bit and one stop bit. The bit period is derived from the system clock by integer division of the clock frequency by the baud rate. The defaults are 50 MHz and 115200 baud, which gives 434 clocks per bit.

Software writes a word whenever `full_o` is low and can poll `empty_o` to learn when every queued word has left the store. A word leaves the store on the cycle its first start bit begins. While the store still holds words, frames follow one another with no idle gap between them. This holds both inside a word and across word boundaries.

Top module: `uart_word_tx`

## Requirements
- R1: After reset, `tx_o` is high, `empty_o` is high and `full_o` is low.
- R2: Each frame is a low start bit, eight data bits with the least significant first, a parity bit and a high stop bit. Every bit lasts CLK_HZ/BAUD_RATE clock cycles.
- R3: The parity bit is chosen so that the data bits plus the parity bit hold an odd number of ones.
- R4: A word is sent as four frames carrying bits [7:0], [15:8], [23:16] and [31:24], in that order.
- R5: With the line idle and the store empty, the start bit of an accepted word begins on the clock edge that follows the edge that stored the word.
- R6: While data remains, the next start bit begins on the same edge that ends the previous stop bit. This applies both within a word and between consecutive stored words.
- R7: Stored words are transmitted in the order they were written.
- R8: `full_o` is high while FIFO_DEPTH words are stored, and it shows so from the cycle after the filling write. A write made while `full_o` is high is dropped and never transmitted.
- R9: `empty_o` is high exactly when no word is stored. A word is removed from the store when its first start bit begins.
- R10: When the store is empty and the last stop bit has ended, `tx_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one word |
| wr_data_i | input | 32 | Word to queue for transmission |
| full_o | output | 1 | Store holds FIFO_DEPTH words |
| empty_o | output | 1 | Store holds no word |
| tx_o | output | 1 | Serial output line, idles high |

## Verification
The first start bit is due on the second clock edge after the write strobe is presented: one edge stores the word and the next one launches it. The bench therefore expects the line low at the first falling edge after that second rising edge. After that, every bit is sampled at its centre, a whole number of bit periods later. At each frame boundary the line is also checked one half clock after the edge on which the next start bit is due, so a single idle cycle between frames is caught. `full_o` and `empty_o` change on the edge that accepts a write or launches a word, so they are read at the falling edge just after it.

// File: rtl/uart_word_tx_pkg.sv
package uart_word_tx_pkg;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 3;

  // LSB-first frame: start(0), data, odd parity, stop(1)
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [BYTE_W-1:0] b);
    return {1'b1, ~^b, b, 1'b0};
  endfunction
endpackage

// File: rtl/uart_word_fifo.sv
module uart_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

  logic [CW-1:0] cnt;

  assign tick_o = run_i && (cnt == CW'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt <= '0;
    else if (!run_i || tick_o) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_word_tx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              avail_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tick_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int BYW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int BTW    = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh;
  logic [WORD_W-1:0]     word_q;
  logic [BTW-1:0]        bit_cnt;
  logic [BYW-1:0]        byte_cnt;
  logic                  active, last_bit, last_byte, word_done;

  assign last_bit  = (bit_cnt == BTW'(FRAME_BITS - 1));
  assign last_byte = (byte_cnt == BYW'(NBYTES - 1));
  assign word_done = active && tick_i && last_bit && last_byte;
  // reload on the stop-bit end so words run back to back
  assign pop_o     = avail_i && (!active || word_done);
  assign busy_o    = active;
  assign tx_o      = active ? sh[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active   <= 1'b0;
      sh       <= '1;
      word_q   <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
    end else if (pop_o) begin
      active   <= 1'b1;
      word_q   <= word_i;
      sh       <= build_frame(word_i[BYTE_W-1:0]);
      bit_cnt  <= '0;
      byte_cnt <= '0;
    end else if (active && tick_i) begin
      if (!last_bit) begin
        sh      <= {1'b1, sh[FRAME_BITS-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
      end else if (!last_byte) begin
        word_q   <= word_q >> BYTE_W;
        sh       <= build_frame(word_q[2*BYTE_W-1:BYTE_W]);
        bit_cnt  <= '0;
        byte_cnt <= byte_cnt + 1'b1;
      end else begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_word_tx.sv
module uart_word_tx #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD_RATE  = 115_200,
  parameter int FIFO_DEPTH = 8,
  parameter int WORD_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              tx_o
);
  localparam int CLKS_PER_BIT = CLK_HZ / BAUD_RATE;

  logic [WORD_W-1:0] head_word;
  logic              fifo_pop, tx_busy, bit_tick;

  uart_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_en_i),
    .data_i  (wr_data_i),
    .pop_i   (fifo_pop),
    .data_o  (head_word),
    .full_o  (full_o),
    .empty_o (empty_o)
  );

  uart_baud_gen #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tx_busy),
    .tick_o (bit_tick)
  );

  uart_frame_tx #(.WORD_W(WORD_W)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .avail_i (!empty_o),
    .word_i  (head_word),
    .tick_i  (bit_tick),
    .pop_o   (fifo_pop),
    .busy_o  (tx_busy),
    .tx_o    (tx_o)
  );
endmodule

// File: rtl/uart_word_tx_chk.sv
module uart_word_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic full_o,
  input logic empty_o,
  input logic tx_o,
  input logic pop_i,
  input logic busy_i
);
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !pop_i |=> full_o); // R8
  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i); // R9
  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !full_o |=> !empty_o); // R9
  AST_START_AFTER_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> !tx_o); // R2
  AST_POP_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && busy_i |-> tx_o); // R6
  AST_NO_POP_LOW_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !tx_o |-> !pop_i); // R6
endmodule

bind uart_word_tx uart_word_tx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .full_o  (full_o),
  .empty_o (empty_o),
  .tx_o    (tx_o),
  .pop_i   (fifo_pop),
  .busy_i  (tx_busy)
);

// File: tb/tb_uart_word_tx.sv
module tb_uart_word_tx;
  localparam int BAUD  = 115_200;
  localparam int CPB   = 4;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        full, empty, tx;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  uart_word_tx #(.CLK_HZ(BAUD * CPB), .BAUD_RATE(BAUD), .FIFO_DEPTH(DEPTH), .WORD_W(32)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .full_o    (full),
    .empty_o   (empty),
    .tx_o      (tx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // chained: start from the previous stop-bit centre sample
  task automatic expect_word(input logic [31:0] w, input bit chained, output int waited);
    logic [7:0] d;
    logic [7:0] e;
    waited = 0;
    for (int b = 0; b < 4; b++) begin
      e = w[8*b +: 8];
      if (b == 0 && !chained) begin
        while (tx !== 1'b0 && waited < 5000) begin
          @(negedge clk);
          waited++;
        end
        repeat (CPB / 2) @(negedge clk);
      end else begin
        repeat (CPB - CPB / 2) @(negedge clk);
        check("R6 no gap before start", {31'b0, tx}, 32'd0);
        repeat (CPB / 2) @(negedge clk);
      end
      check("R2 start bit", {31'b0, tx}, 32'd0);
      for (int i = 0; i < 8; i++) begin
        repeat (CPB) @(negedge clk);
        d[i] = tx;
      end
      check("R4/R7 byte value", {24'b0, d}, {24'b0, e});
      repeat (CPB) @(negedge clk);
      check("R3 odd parity", {31'b0, tx}, {31'b0, ($countones(e) % 2 == 0)});
      repeat (CPB) @(negedge clk);
      check("R2 stop bit", {31'b0, tx}, 32'd1);
    end
  endtask

  task automatic check_idle(input int cycles, input string req);
    int low = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (tx !== 1'b1) low++;
    end
    check(req, low, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w8;
    logic [31:0] fill [DEPTH + 2];
    repeat (3) @(negedge clk);
    check("R1 tx idle", {31'b0, tx}, 32'd1);
    check("R1 empty", {31'b0, empty}, 32'd1);
    check("R1 full", {31'b0, full}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // single word: launch timing, format, idle afterwards
    put(32'hA53C_0F81);
    check("R9 not empty after write", {31'b0, empty}, 32'd0);
    expect_word(32'hA53C_0F81, 1'b0, w8);
    check("R5 start one edge after store", w8, 1);
    check("R9 empty after launch", {31'b0, empty}, 32'd1);
    check_idle(20 * CPB, "R10 idle high");

    // burst beyond capacity: order, full, drop
    for (int k = 0; k < DEPTH + 2; k++) fill[k] = 32'h1000_0000 * (k + 1) + 32'h0102_0304 * k;
    fork
      begin
        for (int k = 0; k < DEPTH + 2; k++) begin
          @(negedge clk);
          if (k == DEPTH + 1) check("R8 full after filling write", {31'b0, full}, 32'd1);
          wr_en = 1'b1;
          wr_data = fill[k];
        end
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 still full after dropped write", {31'b0, full}, 32'd1);
      end
      begin
        for (int k = 0; k <= DEPTH; k++) begin
          expect_word(fill[k], k != 0, w8);
          if (k == DEPTH - 1) check("R9 not empty while words queued", {31'b0, empty}, 32'd0);
        end
      end
    join
    check("R8/R9 empty after last launch", {31'b0, empty}, 32'd1);
    check_idle(50 * CPB, "R8 dropped word never sent");

    // sweep all byte values through one unbroken stream
    fork
      begin
        for (int i = 0; i < 64; i++) begin
          @(negedge clk);
          while (full) @(negedge clk);
          wr_en = 1'b1;
          wr_data = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
          @(negedge clk);
          wr_en = 1'b0;
        end
      end
      begin
        for (int i = 0; i < 64; i++)
          expect_word({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)}, i != 0, w8);
      end
    join
    check("R9 empty after sweep", {31'b0, empty}, 32'd1);
    check_idle(20 * CPB, "R10 idle after sweep");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule